// File: doc/BRIEF.md
# Gated Three-Digit Frequency Counter

This block measures the frequency of a digital input that has already been squared up, and reports it as three BCD digits in the range 0 to 999. It runs from a 32768 Hz reference clock. A prescaler of `DIV_BITS` divide-by-two stages sets the length of one phase. A 2-bit phase sequencer then steps through four phases. The first phase is a clear window, the next two form a count gate lasting two phases, and the last is a hold window. With the default of 14 stages, one phase lasts 0.5 s and the gate lasts exactly one second, so the number of edges counted equals the frequency in Hz.

The input passes through a two-flop synchroniser, and only its rising transitions are counted. Counting happens while the gate is open, in a chain of decade counters where each digit advances when every lower digit is at 9. When the hold window starts, the count is copied into the output register, which keeps it until the next capture. A count above 999 saturates at 999 and sets an overflow flag, which is captured together with the digits.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset the clear window lasts 2^DIV_BITS cycles. It is followed by a gate of 2*2^DIV_BITS cycles, then a hold window of 2^DIV_BITS cycles, and the cycle then repeats from a new clear window.
- R2: In every cycle exactly one of `count_clr`, `gate_open` and `latch_stb` is high. Their order is always clear, then gate, then hold.
- R3: Each rising transition of `sig_in` that reaches the counter while the gate is open adds exactly one to the count. A level held high for several cycles counts once.
- R4: `result_bcd[3:0]` holds the units digit, `[7:4]` the tens digit and `[11:8]` the hundreds digit. Each digit is in the range 0 to 9, and a digit rolling over from 9 carries into the next digit up.
- R5: The count is copied into `result_bcd`/`result_ovf` at the clock edge that ends the first hold cycle. The new value is visible from the second hold cycle. During the first hold cycle the outputs still show the previous value.
- R6: Outside that capture edge, `result_bcd` and `result_ovf` keep their value, including for the whole of the next gate.
- R7: More than 999 edges in one gate give a result of 999 with `result_ovf`=1. Otherwise `result_ovf`=0.
- R8: The counter and its overflow flag are cleared during the clear window. Edges that arrive during the clear window are not counted, and an overflow in one gate does not carry into the next.
- R9: While reset is active and right after it, `result_bcd` is 0, `result_ovf` is 0 and `count_clr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock (32768 Hz in the target use) |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Squared signal to be measured, asynchronous |
| gate_open | output | 1 | High while edges are being counted |
| latch_stb | output | 1 | High during the hold window; its rising edge triggers the capture |
| count_clr | output | 1 | High during the clear window |
| result_bcd | output | 12 | Captured count, three BCD digits |
| result_ovf | output | 1 | Captured overflow flag |

## Verification
A rising edge on `sig_in` reaches the counter three clock edges after it is driven: two synchroniser flops and the edge-detect flop. For this reason the bench starts its pulse trains three cycles after it sees the gate open, and ends them with margin before the gate closes. The captured result changes one edge after `latch_stb` rises. The bench checks the old value in the first hold cycle and the new value in the second, and it sees the phase outputs one cycle after each prescaler wrap. All outputs are sampled at the falling clock edge. With `DIV_BITS`=10 the gate lasts 2048 cycles, long enough for more than 999 one-cycle pulses, so saturation can be reached.

// File: rtl/fmc_pkg.sv
package fmc_pkg;

  localparam int unsigned BCD_W = 4;

  typedef logic [BCD_W-1:0] bcd_t;

  typedef enum logic [1:0] {
    PH_CLEAR  = 2'd0,
    PH_GATE_A = 2'd1,
    PH_GATE_B = 2'd2,
    PH_HOLD   = 2'd3
  } phase_e;

  // next value of one decade digit, wrapping 9 -> 0
  function automatic bcd_t bcd_step(input bcd_t d);
    return (d == bcd_t'(9)) ? '0 : bcd_t'(d + bcd_t'(1));
  endfunction

  function automatic logic bcd_is_max(input bcd_t d);
    return d == bcd_t'(9);
  endfunction

  // phase sequencer successor
  function automatic phase_e phase_next(input phase_e p);
    case (p)
      PH_CLEAR:  return PH_GATE_A;
      PH_GATE_A: return PH_GATE_B;
      PH_GATE_B: return PH_HOLD;
      default:   return PH_CLEAR;
    endcase
  endfunction

endpackage

// File: rtl/fmc_timebase.sv
module fmc_timebase
  import fmc_pkg::*;
#(
  parameter int unsigned DIV_BITS = 14
) (
  input  logic clk,
  input  logic rst_n,
  output logic gate_o,
  output logic hold_o,
  output logic clr_o
);

  logic [DIV_BITS-1:0] presc_q;
  logic                wrap;
  phase_e              phase_q;

  assign wrap = &presc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc_q <= '0;
      phase_q <= PH_CLEAR;
    end else begin
      presc_q <= presc_q + 1'b1;
      if (wrap) phase_q <= phase_next(phase_q);
    end
  end

  assign clr_o  = (phase_q == PH_CLEAR);
  assign gate_o = (phase_q == PH_GATE_A) || (phase_q == PH_GATE_B);
  assign hold_o = (phase_q == PH_HOLD);

endmodule

// File: rtl/fmc_edge_sync.sv
module fmc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/fmc_decade_chain.sv
module fmc_decade_chain
  import fmc_pkg::*;
#(
  parameter int unsigned DIGITS = 3,
  localparam int unsigned W = DIGITS * BCD_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] digits_o,
  output logic         ovf_o
);

  bcd_t          dig_q [DIGITS];
  logic [DIGITS:0] lower_max;
  logic          full;
  logic          step;
  logic          ovf_q;

  assign lower_max[0] = 1'b1;
  assign full = lower_max[DIGITS];
  assign step = inc_i & ~full;

  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign lower_max[g+1] = lower_max[g] & bcd_is_max(dig_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n || clr_i)             dig_q[g] <= '0;
      else if (step && lower_max[g])   dig_q[g] <= bcd_step(dig_q[g]);
    end

    assign digits_o[g*BCD_W +: BCD_W] = dig_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr_i)    ovf_q <= 1'b0;
    else if (inc_i && full) ovf_q <= 1'b1;
  end

  assign ovf_o = ovf_q;

endmodule

// File: rtl/gated_freq_counter.sv
module gated_freq_counter
  import fmc_pkg::*;
#(
  parameter int unsigned DIV_BITS    = 14,
  parameter int unsigned DIGITS      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned RES_W = DIGITS * BCD_W
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             sig_in,
  output logic             gate_open,
  output logic             latch_stb,
  output logic             count_clr,
  output logic [RES_W-1:0] result_bcd,
  output logic             result_ovf
);

  logic             sig_rise;
  logic             count_en;
  logic [RES_W-1:0] live_digits;
  logic             live_ovf;
  logic             hold_q;
  logic             cap_en;
  logic [RES_W-1:0] res_q;
  logic             res_ovf_q;

  fmc_timebase #(.DIV_BITS(DIV_BITS)) u_tb (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .gate_o (gate_open),
    .hold_o (latch_stb),
    .clr_o  (count_clr)
  );

  fmc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk_ref),
    .rst_n  (rst_n),
    .din    (sig_in),
    .rise_o (sig_rise)
  );

  assign count_en = gate_open & sig_rise;

  fmc_decade_chain #(.DIGITS(DIGITS)) u_cnt (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .clr_i    (count_clr),
    .inc_i    (count_en),
    .digits_o (live_digits),
    .ovf_o    (live_ovf)
  );

  // capture on the first cycle of the hold window
  always_ff @(posedge clk_ref) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= latch_stb;
  end

  assign cap_en = latch_stb & ~hold_q;

  always_ff @(posedge clk_ref) begin
    if (!rst_n) begin
      res_q     <= '0;
      res_ovf_q <= 1'b0;
    end else if (cap_en) begin
      res_q     <= live_digits;
      res_ovf_q <= live_ovf;
    end
  end

  assign result_bcd = res_q;
  assign result_ovf = res_ovf_q;

endmodule

// File: rtl/fmc_checker.sv
module fmc_checker #(
  parameter int unsigned DIGITS = 3,
  localparam int unsigned RES_W = DIGITS * 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             gate,
  input logic             hold,
  input logic             clr,
  input logic             cap_en,
  input logic             count_en,
  input logic [RES_W-1:0] result,
  input logic             ovf
);

  localparam logic [RES_W-1:0] ALL_NINES = {DIGITS{4'h9}};

  function automatic logic digits_valid(input logic [RES_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[i*4 +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gate, hold, clr}) == 1);

  // R2
  gate_after_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(clr));

  // R2
  hold_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(gate));

  // R2
  clr_after_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clr) |-> $past(hold));

  // R8
  no_count_in_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> !count_en);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_en) |-> ($stable(result) && $stable(ovf)));

  // R4
  digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    digits_valid(result));

  // R7
  ovf_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (result == ALL_NINES));

endmodule

bind gated_freq_counter fmc_checker #(.DIGITS(DIGITS)) chk_i (
  .clk      (clk_ref),
  .rst_n    (rst_n),
  .gate     (gate_open),
  .hold     (latch_stb),
  .clr      (count_clr),
  .cap_en   (cap_en),
  .count_en (count_en),
  .result   (result_bcd),
  .ovf      (result_ovf)
);

// File: tb/gated_freq_counter_tb.sv
module gated_freq_counter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_BITS   = 10;
  localparam int PHASE_LEN  = 1 << DIV_BITS;

  logic        clk_ref = 1'b0;
  logic        rst_n;
  logic        sig_in;
  logic        gate_open, latch_stb, count_clr;
  logic [11:0] result_bcd;
  logic        result_ovf;

  int errors = 0;
  int checks = 0;
  logic [11:0] prev_bcd;
  logic        prev_ovf;

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  gated_freq_counter #(.DIV_BITS(DIV_BITS), .DIGITS(3), .SYNC_STAGES(2)) dut_i (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .sig_in     (sig_in),
    .gate_open  (gate_open),
    .latch_stb  (latch_stb),
    .count_clr  (count_clr),
    .result_bcd (result_bcd),
    .result_ovf (result_ovf)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic logic [11:0] to_bcd(input int v);
    return 12'((v / 100) * 256 + ((v / 10) % 10) * 16 + (v % 10));
  endfunction

  task automatic measure_len(input int which, input int exp, input string req);
    int n;
    n = 0;
    while ((which == 0 && count_clr) || (which == 1 && gate_open) || (which == 2 && latch_stb)) begin
      n++;
      @(negedge clk_ref);
    end
    check(n == exp, req, n, exp);
  endtask

  task automatic pulses(input int n, input int hi, input int lo);
    for (int k = 0; k < n; k++) begin
      sig_in = 1'b1;
      repeat (hi) @(negedge clk_ref);
      sig_in = 1'b0;
      repeat (lo) @(negedge clk_ref);
    end
  endtask

  task automatic run_window(input int n, input int hi, input int lo);
    int exp_v;
    // edges in the clear window must not survive (R8)
    while (!count_clr) @(negedge clk_ref);
    repeat (2) @(negedge clk_ref);
    pulses(7, 1, 1);
    while (!gate_open) @(negedge clk_ref);
    check(result_bcd == prev_bcd, "R6 hold at gate start", int'(result_bcd), int'(prev_bcd));
    repeat (3) @(negedge clk_ref);
    pulses(n, hi, lo);
    check(result_bcd == prev_bcd && result_ovf == prev_ovf, "R6 hold during gate",
          int'(result_bcd), int'(prev_bcd));
    while (!latch_stb) @(negedge clk_ref);
    check(result_bcd == prev_bcd, "R5 old value in first hold cycle", int'(result_bcd), int'(prev_bcd));
    @(negedge clk_ref);
    exp_v = (n > 999) ? 999 : n;
    check(result_bcd == to_bcd(exp_v), $sformatf("R3 R4 R7 count n=%0d", n),
          int'(result_bcd), int'(to_bcd(exp_v)));
    check(result_ovf == (n > 999), $sformatf("R7 R8 overflow n=%0d", n),
          int'(result_ovf), int'(n > 999));
    prev_bcd = to_bcd(exp_v);
    prev_ovf = (n > 999);
  endtask

  initial begin
    rst_n  = 1'b0;
    sig_in = 1'b0;
    repeat (4) @(negedge clk_ref);
    check(result_bcd == 12'h000 && result_ovf == 1'b0, "R9 reset result", int'(result_bcd), 0);
    check(count_clr == 1'b1, "R9 clear during reset", int'(count_clr), 1);
    rst_n = 1'b1;
    check({count_clr, gate_open, latch_stb} == 3'b100, "R9 R2 phase after reset",
          int'({count_clr, gate_open, latch_stb}), 4);
    measure_len(0, PHASE_LEN, "R1 first clear length");
    measure_len(1, 2 * PHASE_LEN, "R1 gate length");
    measure_len(2, PHASE_LEN, "R1 hold length");
    check(result_bcd == 12'h000 && result_ovf == 1'b0, "R3 idle input gives zero", int'(result_bcd), 0);
    measure_len(0, PHASE_LEN, "R1 R2 clear after hold");
    prev_bcd = 12'h000;
    prev_ovf = 1'b0;
    run_window(1, 1, 1);
    run_window(9, 1, 1);
    run_window(10, 1, 1);
    run_window(99, 1, 1);
    run_window(100, 1, 1);
    run_window(123, 1, 1);
    run_window(150, 5, 5);   // R3 wide pulses count once each
    run_window(500, 2, 1);
    run_window(998, 1, 1);
    run_window(999, 1, 1);
    run_window(1000, 1, 1);
    run_window(1010, 1, 1);
    run_window(5, 1, 1);     // R8 overflow does not carry over
    run_window(0, 1, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_ref);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule